// File: doc/BRIEF.md
# Harvard-Bus Memory Chip-Select Decoder

This block produces the chip selects for a microcontroller bus that keeps program space and data space apart. Instruction fetches arrive with a code strobe and data reads with a read strobe. Data writes use a write strobe. From these strobes, the latched address, a static space-mode input and a small control register, the block drives four active-low EPROM block selects and one active-low SRAM select. All selects are registered.

There are two space modes. In separate-space mode, EPROM serves code only and SRAM serves data only, so code and data addresses may reuse the same numbers. In combined-space mode, EPROM answers both fetches and data reads, and its windows are expected not to overlap any other window.

A control register bit lets SRAM hold executable code. When that bit is set, a fetch that falls inside the SRAM window selects SRAM. This happens even where an EPROM window covers the same address. Each address window is a base/mask pair fixed by parameters.

Top module: `hbus_csel`

## Requirements
- R1: Every select is registered and active-low. A select reflects the strobes and address of the previous clock cycle. When no strobe was active, all selects are high.
- R2: At most one of the five selects is low in any cycle.
- R3: In separate-space mode with the code-in-SRAM bit clear, a fetch drives low the select of the lowest-indexed EPROM window matching the address, and never the SRAM select. Default windows: block i covers base i*0x2000 under mask 0xE000. The SRAM window is base 0x0000 under mask 0xF800.
- R4: In separate-space mode, a data read selects SRAM when the address is in the SRAM window, and never selects an EPROM block.
- R5: In combined-space mode (`combined_space`=1), a fetch or a data read selects the matching EPROM block. A data read that matches no EPROM window selects SRAM if the address is in the SRAM window.
- R6: A write strobe selects SRAM when the address is in the SRAM window, in both modes, and never selects an EPROM block.
- R7: With control bit 1 (code-in-SRAM) set, a fetch inside the SRAM window selects SRAM, and the overlapping EPROM select stays high. Fetches outside the SRAM window behave as in R3/R5.
- R8: Control bits 7..2 read as zero and ignore writes. Bit 0 is stored and reads back, but has no effect on any select. The read data reflects a write from the cycle after it.
- R9: Reset clears the control register to 0x00 and drives all selects high.
- R10: When several strobes are active together, the fetch strobe takes precedence over read, and read takes precedence over write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Latched bus address |
| code_strb_n | input | 1 | Program fetch strobe, active low |
| data_rd_n | input | 1 | Data read strobe, active low |
| data_wr_n | input | 1 | Data write strobe, active low |
| combined_space | input | 1 | Static mode: 1 combined, 0 separate |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| rom_sel_n | output | NUM_ROM | EPROM block selects, active low |
| ram_sel_n | output | 1 | SRAM select, active low |

## Verification
Every select is due exactly one clock edge after the address and strobes are applied. The bench therefore drives each pattern on a falling edge, lets one rising edge pass, and compares on the next falling edge. It does not look earlier or later than that. A control-register write takes effect at the edge that captures it, so the bench writes first and then waits one full cycle before it sends any strobe that depends on the register. The sweeps cover every address page, every combination of strobes, both modes and four register values.

// File: rtl/hbus_csel_pkg.sv
package hbus_csel_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_READ  = 2'd2,
    CYC_WRITE = 2'd3
  } cyc_kind_e;

  localparam int CTL_W        = 8;
  localparam int CTL_CODE_BIT = 1;
  localparam int CTL_AUX_BIT  = 0;
  localparam int CTL_USED     = 2;
endpackage

// File: rtl/hbus_window_match.sv
module hbus_window_match #(
  parameter int ADDR_W  = 16,
  parameter int NUM_WIN = 4,
  parameter logic [NUM_WIN*ADDR_W-1:0] BASES = '0,
  parameter logic [NUM_WIN*ADDR_W-1:0] MASKS = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_WIN-1:0] hit
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE_G = BASES[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] MASK_G = MASKS[g*ADDR_W +: ADDR_W];
    assign hit[g] = ((addr & MASK_G) == (BASE_G & MASK_G));
  end
endmodule

// File: rtl/hbus_prio_pick.sv
module hbus_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_pick
    assign gnt[g]    = req[g] & ~seen[g];
    assign seen[g+1] = seen[g] | req[g];
  end
  assign any = seen[N];
endmodule

// File: rtl/hbus_ctrl_reg.sv
module hbus_ctrl_reg
  import hbus_csel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic             code_in_ram,
  output logic [CTL_W-1:0] rdata
);
  logic [CTL_USED-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else if (we) held_q <= wdata[CTL_USED-1:0];
  end

  assign code_in_ram = held_q[CTL_CODE_BIT];
  assign rdata       = {{(CTL_W-CTL_USED){1'b0}}, held_q};
endmodule

// File: rtl/hbus_csel.sv
module hbus_csel
  import hbus_csel_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_ROM = 4,
  parameter logic [NUM_ROM*ADDR_W-1:0] ROM_BASE = {16'h6000, 16'h4000, 16'h2000, 16'h0000},
  parameter logic [NUM_ROM*ADDR_W-1:0] ROM_MASK = {NUM_ROM{16'hE000}},
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h0000,
  parameter logic [ADDR_W-1:0] RAM_MASK = 16'hF800
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               code_strb_n,
  input  logic               data_rd_n,
  input  logic               data_wr_n,
  input  logic               combined_space,
  input  logic               ctl_we,
  input  logic [7:0]         ctl_wdata,
  output logic [7:0]         ctl_rdata,
  output logic [NUM_ROM-1:0] rom_sel_n,
  output logic               ram_sel_n
);
  logic [NUM_ROM-1:0] rom_hit, rom_pick, rom_nxt;
  logic               rom_any, ram_hit, ram_nxt, code_in_ram;
  cyc_kind_e          kind;

  hbus_ctrl_reg u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .code_in_ram(code_in_ram), .rdata(ctl_rdata)
  );

  hbus_window_match #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_ROM), .BASES(ROM_BASE), .MASKS(ROM_MASK)
  ) u_rom_win (.addr(bus_addr), .hit(rom_hit));

  hbus_window_match #(
    .ADDR_W(ADDR_W), .NUM_WIN(1), .BASES(RAM_BASE), .MASKS(RAM_MASK)
  ) u_ram_win (.addr(bus_addr), .hit(ram_hit));

  hbus_prio_pick #(.N(NUM_ROM)) u_pick (.req(rom_hit), .gnt(rom_pick), .any(rom_any));

  // strobe precedence: fetch, then read, then write
  always_comb begin
    if (!code_strb_n)    kind = CYC_FETCH;
    else if (!data_rd_n) kind = CYC_READ;
    else if (!data_wr_n) kind = CYC_WRITE;
    else                 kind = CYC_IDLE;
  end

  always_comb begin
    rom_nxt = '0;
    ram_nxt = 1'b0;
    unique case (kind)
      CYC_FETCH: begin
        if (code_in_ram && ram_hit) ram_nxt = 1'b1;
        else                        rom_nxt = rom_pick;
      end
      CYC_READ: begin
        if (combined_space && rom_any) rom_nxt = rom_pick;
        else                           ram_nxt = ram_hit;
      end
      CYC_WRITE: ram_nxt = ram_hit;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_sel_n <= '1;
      ram_sel_n <= 1'b1;
    end else begin
      rom_sel_n <= ~rom_nxt;
      ram_sel_n <= ~ram_nxt;
    end
  end
endmodule

// File: rtl/hbus_csel_chk.sv
module hbus_csel_chk #(
  parameter int NUM_ROM = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               code_strb_n,
  input logic               data_rd_n,
  input logic               data_wr_n,
  input logic               combined_space,
  input logic [7:0]         ctl_rdata,
  input logic [NUM_ROM-1:0] rom_sel_n,
  input logic               ram_sel_n
);
  assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(~{rom_sel_n, ram_sel_n}) <= 1);

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (rst)
    (code_strb_n && data_rd_n && data_wr_n) |=> (&rom_sel_n && ram_sel_n));

  assert_write_no_rom_R6: assert property (@(posedge clk) disable iff (rst)
    (code_strb_n && data_rd_n && !data_wr_n) |=> &rom_sel_n);

  assert_sep_read_no_rom_R4: assert property (@(posedge clk) disable iff (rst)
    (!combined_space && code_strb_n && !data_rd_n) |=> &rom_sel_n);

  assert_fetch_no_ram_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rdata[1] && !code_strb_n) |=> ram_sel_n);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[7:2] == 6'd0);
endmodule

bind hbus_csel hbus_csel_chk #(.NUM_ROM(NUM_ROM)) u_chk (
  .clk(clk), .rst(rst), .code_strb_n(code_strb_n), .data_rd_n(data_rd_n),
  .data_wr_n(data_wr_n), .combined_space(combined_space), .ctl_rdata(ctl_rdata),
  .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n)
);

// File: tb/test_hbus_csel.sv
module test_hbus_csel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        code_strb_n = 1'b1, data_rd_n = 1'b1, data_wr_n = 1'b1;
  logic        combined_space = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic [3:0]  rom_sel_n;
  logic        ram_sel_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  hbus_csel i_hbus_csel (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .code_strb_n(code_strb_n),
    .data_rd_n(data_rd_n), .data_wr_n(data_wr_n), .combined_space(combined_space),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected active-high {ram, rom[3:0]}
  function automatic logic [4:0] model(input logic comb, input logic code_ram,
                                       input logic f, input logic r, input logic w,
                                       input logic [15:0] a);
    logic [2:0] blk;
    logic       rom_hit, ram_hit;
    logic [4:0] res;
    blk     = a[15:13];
    rom_hit = (blk < 3'd4);
    ram_hit = (a[15:11] == 5'd0);
    res     = '0;
    if (f) begin
      if (code_ram && ram_hit) res[4] = 1'b1;
      else if (rom_hit)        res[blk[1:0]] = 1'b1;
    end else if (r) begin
      if (comb && rom_hit) res[blk[1:0]] = 1'b1;
      else if (ram_hit)    res[4] = 1'b1;
    end else if (w) begin
      if (ram_hit) res[4] = 1'b1;
    end
    return res;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] regv [4];
    regv[0] = 8'h00; regv[1] = 8'h01; regv[2] = 8'hFE; regv[3] = 8'hFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset selects", {3'b0, ram_sel_n, rom_sel_n}, 8'h1F);
    check("R9 reset ctl", ctl_rdata, 8'h00);

    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 4; k++) begin
        combined_space = m[0];
        ctl_we = 1'b1; ctl_wdata = regv[k];
        @(negedge clk);
        ctl_we = 1'b0;
        check("R8 ctl readback", ctl_rdata, {6'b0, regv[k][1:0]});
        for (int s = 0; s < 8; s++) begin
          for (int p = 0; p < 256; p++) begin
            logic [15:0] a;
            logic [4:0]  e;
            string       tg;
            a = {p[7:0], p[7:0] ^ 8'hA5};
            code_strb_n = ~s[0]; data_rd_n = ~s[1]; data_wr_n = ~s[2];
            bus_addr = a;
            e = model(m[0], regv[k][1], s[0], s[1], s[2], a);
            if ($countones(s[2:0]) > 1) tg = "R10 multi-strobe";
            else if (s[0] && regv[k][1]) tg = "R7 fetch code-in-ram";
            else if (s[0]) tg = (m == 1) ? "R5 fetch combined" : "R3 fetch separate";
            else if (s[1]) tg = (m == 1) ? "R5 read combined" : "R4 read separate";
            else if (s[2]) tg = "R6 write";
            else tg = "R1 idle";
            @(negedge clk);
            check(tg, {3'b0, ram_sel_n, rom_sel_n}, {3'b0, ~e});
            check("R2 at most one", 8'($countones(~{ram_sel_n, rom_sel_n}) > 1), 8'h00);
          end
        end
        code_strb_n = 1'b1; data_rd_n = 1'b1; data_wr_n = 1'b1;
        @(negedge clk);
        check("R1 release", {3'b0, ram_sel_n, rom_sel_n}, 8'h1F);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule